// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Detection

This block is a sixteen-pin general-purpose I/O controller reached through a small memory-mapped register bus. Every pin is either driven by an output latch or sampled as an input. Software changes output bits through dedicated set and clear strobe registers, so one pin can be toggled without first reading the latch back. Pin inputs are resynchronised into the core clock domain. The synchronised value is readable and feeds a per-pin interrupt detector.

Each detector is programmed either for level triggering, active-high or active-low, or for edge triggering on the rising edge, the falling edge, or both. Edge events are held in a pending latch until software acknowledges them. A level condition stays pending for as long as the level holds. Pending bits pass a mask gate and a separate enable gate. The surviving bits are visible in a status register and are ORed into a single registered interrupt line.

The register bus has no back-pressure. A write is taken on any clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`, so no valid/ready handshake is needed on either side. Pads and pin multiplexing sit outside this block.

Top module: `pin_ctrl_irq`

## Requirements
- R1: After reset, the mask register (byte offset 0x28) reads 0xFFFF. The enable register (0x2C), direction (0x00), output latch (0x20), status (0x30), `pin_oe`, `pin_out` and `irq_out` all read 0.
- R2: Writing the direction register at 0x00 sets `pin_oe` to the written value from the next cycle on, where bit 1 means the pin is an output. The value reads back at 0x00.
- R3: Writing to 0x18 sets every output latch bit whose written bit is 1. Writing to 0x1C clears every latch bit whose written bit is 1. Bits written as 0 keep their value. The latch drives `pin_out` and reads back at 0x20.
- R4: The input register at 0x14 returns `pin_in` through a two-stage synchroniser. A change made before clock edge k is readable after edge k+1 and not after edge k.
- R5: When a pin's bit in the level-select register (0x04) is 1, its raw pending bit equals 1 exactly while the synchronised input equals its polarity bit (0x08; 1 = high, 0 = low). An acknowledge write does not remove it.
- R6: When the level-select bit is 0, a synchronised 0→1 transition latches pending if the rising-enable bit (0x0C) is set. A 1→0 transition latches pending if the falling-enable bit (0x10) is set. The latch holds until acknowledged.
- R7: The status register at 0x30 shows raw pending bits only for pins whose mask bit (0x28) is 0 and whose enable bit (0x2C) is 1. Writing 0xFFFF to the mask forces status to 0 on the next cycle.
- R8: Writing 1s to 0x34 clears the matching latched edge pending bits. An edge detected in the same cycle as its acknowledge leaves the bit set.
- R9: `irq_out` is a registered OR of the status bits. It is 1 one cycle after any status bit is 1 and 0 one cycle after status is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, taken at the rising clock edge |
| bus_addr | input | 6 | Register byte offset for read and write |
| bus_wdata | input | 16 | Write data, one bit per pin |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output latch value toward the pads |
| pin_oe | output | 16 | Output enable per pin (direction register) |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
The detector is swept over every pin in five trigger configurations: level-high, level-low, rising, falling and both edges. Each sweep runs one fixed low-high-low pin pattern with acknowledges in between. Comparing the status after each step tells level behaviour, which survives an acknowledge, apart from latched edge behaviour, which does not. It also tells the edge polarities apart from each other. Separate patterns hit an edge and an acknowledge in the same cycle, and step the mask and enable gates one at a time. Set and clear strobes use overlapping bit patterns to show that untouched bits hold. The data-in read is sampled one edge and two edges after an input change to pin down the synchroniser depth.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_DIR  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_LSEL = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_LPOL = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_RISE = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_FALL = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_DIN  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_SET  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_DOUT = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_MASK = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_EN   = 6'h2C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_ACK  = 6'h34;

  typedef enum logic [3:0] {
    SEL_DIR, SEL_LSEL, SEL_LPOL, SEL_RISE, SEL_FALL, SEL_DIN, SEL_SET,
    SEL_CLR, SEL_DOUT, SEL_MASK, SEL_EN, SEL_STAT, SEL_ACK, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_DIR:  return SEL_DIR;
      OFS_LSEL: return SEL_LSEL;
      OFS_LPOL: return SEL_LPOL;
      OFS_RISE: return SEL_RISE;
      OFS_FALL: return SEL_FALL;
      OFS_DIN:  return SEL_DIN;
      OFS_SET:  return SEL_SET;
      OFS_CLR:  return SEL_CLR;
      OFS_DOUT: return SEL_DOUT;
      OFS_MASK: return SEL_MASK;
      OFS_EN:   return SEL_EN;
      OFS_STAT: return SEL_STAT;
      OFS_ACK:  return SEL_ACK;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cur,
  input  logic prev,
  input  logic lvl_sel,
  input  logic lvl_pol,
  input  logic rise_en,
  input  logic fall_en,
  input  logic ack,
  output logic raw
);
  logic edge_hit;
  logic pend_q;

  assign edge_hit = !lvl_sel &&
                    ((rise_en && cur && !prev) || (fall_en && !cur && prev));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (lvl_sel)  pend_q <= 1'b0;
    else if (edge_hit) pend_q <= 1'b1;
    else if (ack)      pend_q <= 1'b0;
  end

  assign raw = lvl_sel ? (cur == lvl_pol) : pend_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPIN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] din,
  input  logic [NPIN-1:0] lvl_sel,
  input  logic [NPIN-1:0] lvl_pol,
  input  logic [NPIN-1:0] rise_en,
  input  logic [NPIN-1:0] fall_en,
  input  logic [NPIN-1:0] mask,
  input  logic [NPIN-1:0] en,
  input  logic [NPIN-1:0] ack,
  output logic [NPIN-1:0] stat
);
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= din;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_cell
    gpio_irq_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .cur     (din[i]),
      .prev    (prev_q[i]),
      .lvl_sel (lvl_sel[i]),
      .lvl_pol (lvl_pol[i]),
      .rise_en (rise_en[i]),
      .fall_en (fall_en[i]),
      .ack     (ack[i]),
      .raw     (raw[i])
    );
  end

  assign stat = raw & ~mask & en;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   din,
  input  logic [NPIN-1:0]   stat,
  output logic [NPIN-1:0]   dir,
  output logic [NPIN-1:0]   lvl_sel,
  output logic [NPIN-1:0]   lvl_pol,
  output logic [NPIN-1:0]   rise_en,
  output logic [NPIN-1:0]   fall_en,
  output logic [NPIN-1:0]   dout,
  output logic [NPIN-1:0]   mask,
  output logic [NPIN-1:0]   en,
  output logic [NPIN-1:0]   ack
);
  reg_sel_e sel;
  assign sel = decode_addr(bus_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir     <= '0;
      lvl_sel <= '0;
      lvl_pol <= '0;
      rise_en <= '0;
      fall_en <= '0;
      dout    <= '0;
      mask    <= '1;
      en      <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_DIR:  dir     <= bus_wdata;
        SEL_LSEL: lvl_sel <= bus_wdata;
        SEL_LPOL: lvl_pol <= bus_wdata;
        SEL_RISE: rise_en <= bus_wdata;
        SEL_FALL: fall_en <= bus_wdata;
        SEL_SET:  dout    <= dout | bus_wdata;
        SEL_CLR:  dout    <= dout & ~bus_wdata;
        SEL_MASK: mask    <= bus_wdata;
        SEL_EN:   en      <= bus_wdata;
        default:  ;
      endcase
    end
  end

  assign ack = (bus_wr && sel == SEL_ACK) ? bus_wdata : '0;

  always_comb begin
    case (sel)
      SEL_DIR:  bus_rdata = dir;
      SEL_LSEL: bus_rdata = lvl_sel;
      SEL_LPOL: bus_rdata = lvl_pol;
      SEL_RISE: bus_rdata = rise_en;
      SEL_FALL: bus_rdata = fall_en;
      SEL_DIN:  bus_rdata = din;
      SEL_DOUT: bus_rdata = dout;
      SEL_MASK: bus_rdata = mask;
      SEL_EN:   bus_rdata = en;
      SEL_STAT: bus_rdata = stat;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pin_ctrl_irq.sv
module pin_ctrl_irq
  import gpio_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              irq_out
);
  logic [NPIN-1:0] din_s;
  logic [NPIN-1:0] lvl_sel, lvl_pol, rise_en, fall_en;
  logic [NPIN-1:0] mask_r, en_r, ack_w, stat_w;

  gpio_sync2 #(.W(NPIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (din_s)
  );

  gpio_regs #(.NPIN(NPIN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .din       (din_s),
    .stat      (stat_w),
    .dir       (pin_oe),
    .lvl_sel   (lvl_sel),
    .lvl_pol   (lvl_pol),
    .rise_en   (rise_en),
    .fall_en   (fall_en),
    .dout      (pin_out),
    .mask      (mask_r),
    .en        (en_r),
    .ack       (ack_w)
  );

  gpio_irq_bank #(.NPIN(NPIN)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din_s),
    .lvl_sel (lvl_sel),
    .lvl_pol (lvl_pol),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .mask    (mask_r),
    .en      (en_r),
    .ack     (ack_w),
    .stat    (stat_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= |stat_w;
  end
endmodule

// File: rtl/gpio_chk.sv
module gpio_chk
  import gpio_pkg::*;
#(
  parameter int NPIN = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPIN-1:0]   bus_wdata,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe,
  input logic              irq_out,
  input logic [NPIN-1:0]   stat
);
  AST_DIR_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DIR) |=> (pin_oe == $past(bus_wdata))); // R2

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_SET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata))); // R3

  AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CLR) |=> ((pin_out & $past(bus_wdata)) == '0)); // R3

  AST_MASK_ALL_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_MASK && (&bus_wdata)) |=> (stat == '0)); // R7

  AST_MASK_ALL_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_MASK && (&bus_wdata)) |=> ##1 !irq_out); // R9
endmodule

bind pin_ctrl_irq gpio_chk #(.NPIN(NPIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq_out   (irq_out),
  .stat      (stat_w)
);

// File: tb/tb_pin_ctrl_irq.sv
module tb_pin_ctrl_irq;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_DIR = 6'h00, A_LSEL = 6'h04, A_LPOL = 6'h08,
    A_RISE = 6'h0C, A_FALL = 6'h10, A_DIN = 6'h14, A_SET = 6'h18,
    A_CLR = 6'h1C, A_DOUT = 6'h20, A_MASK = 6'h28, A_EN = 6'h2C,
    A_STAT = 6'h30, A_ACK = 6'h34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq_out;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_ctrl_irq dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_stat(input string tag, input logic [15:0] exp);
    logic [15:0] v;
    rd(A_STAT, v);
    chk(tag, v, exp);
    chk("R9 irq", {15'b0, irq_out}, {15'b0, exp != 16'h0});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(A_MASK, v); chk("R1 mask", v, 16'hFFFF);
    rd(A_EN, v);   chk("R1 enable", v, 16'h0000);
    rd(A_DIR, v);  chk("R1 dir", v, 16'h0000);
    rd(A_DOUT, v); chk("R1 dout", v, 16'h0000);
    rd(A_STAT, v); chk("R1 stat", v, 16'h0000);
    chk("R1 pin_oe", pin_oe, 16'h0000);
    chk("R1 pin_out", pin_out, 16'h0000);
    chk("R1 irq", {15'b0, irq_out}, 16'h0000);

    // R2 direction
    wr(A_DIR, 16'hA5C3);
    chk("R2 pin_oe", pin_oe, 16'hA5C3);
    rd(A_DIR, v); chk("R2 readback", v, 16'hA5C3);

    // R3 set and clear strobes
    wr(A_SET, 16'h00F0); chk("R3 set", pin_out, 16'h00F0);
    wr(A_SET, 16'h0003); chk("R3 set keeps", pin_out, 16'h00F3);
    wr(A_CLR, 16'h0010); chk("R3 clr", pin_out, 16'h00E3);
    wr(A_CLR, 16'h0000); chk("R3 clr zero", pin_out, 16'h00E3);
    rd(A_DOUT, v); chk("R3 readback", v, 16'h00E3);

    // R4 synchroniser latency
    @(negedge clk);
    pin_in = 16'hBEEF; bus_addr = A_DIN;
    @(posedge clk); #1 chk("R4 one edge", bus_rdata, 16'h0000);
    @(posedge clk); #1 chk("R4 two edges", bus_rdata, 16'hBEEF);
    @(negedge clk); pin_in = 16'h0000;
    idle(4);

    // R5 R6 R8 R9 sweep: pin x mode, pattern low-high-ack-low-ack
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 5; m++) begin
        logic [15:0] b;
        logic lvl, pol, re, fe, pend, pin;
        string tg;
        b = 16'h1 << p;
        lvl = (m < 2); pol = (m == 0);
        re = (m == 2 || m == 4); fe = (m == 3 || m == 4);
        tg = lvl ? "R5 level" : "R6 edge";
        wr(A_LSEL, lvl ? b : 16'h0);
        wr(A_LPOL, pol ? b : 16'h0);
        wr(A_RISE, re ? b : 16'h0);
        wr(A_FALL, fe ? b : 16'h0);
        wr(A_MASK, ~b);
        wr(A_EN, b);
        wr(A_ACK, 16'hFFFF);
        idle(2);
        pend = 1'b0; pin = 1'b0;
        chk_stat(tg, (lvl ? (pin == pol) : pend) ? b : 16'h0);
        // rise
        @(negedge clk); pin_in = b; pin = 1'b1; idle(4);
        if (re) pend = 1'b1;
        chk_stat(tg, (lvl ? (pin == pol) : pend) ? b : 16'h0);
        wr(A_ACK, b); idle(2); pend = 1'b0;
        chk_stat("R8 ack", (lvl ? (pin == pol) : pend) ? b : 16'h0);
        // fall
        @(negedge clk); pin_in = 16'h0; pin = 1'b0; idle(4);
        if (fe) pend = 1'b1;
        chk_stat(tg, (lvl ? (pin == pol) : pend) ? b : 16'h0);
        wr(A_ACK, b); idle(2); pend = 1'b0;
        chk_stat("R8 ack", (lvl ? (pin == pol) : pend) ? b : 16'h0);
      end
    end

    // R7 gating: pin 0 rising edge pending, gates stepped
    wr(A_LSEL, 16'h0); wr(A_FALL, 16'h0); wr(A_RISE, 16'h0001);
    wr(A_MASK, 16'hFFFF); wr(A_EN, 16'h0001); wr(A_ACK, 16'hFFFF);
    @(negedge clk); pin_in = 16'h0001; idle(4);
    chk_stat("R7 masked", 16'h0000);
    wr(A_MASK, 16'hFFFE); wr(A_EN, 16'h0000); idle(2);
    chk_stat("R7 disabled", 16'h0000);
    wr(A_EN, 16'h0001); idle(2);
    chk_stat("R7 open", 16'h0001);
    wr(A_MASK, 16'hFFFF); idle(2);
    chk_stat("R7 remask", 16'h0000);
    @(negedge clk); pin_in = 16'h0000;
    wr(A_ACK, 16'hFFFF); idle(4);

    // R8 edge and acknowledge in the same cycle: edge wins
    wr(A_RISE, 16'h0008); wr(A_MASK, 16'hFFF7); wr(A_EN, 16'h0008);
    wr(A_ACK, 16'hFFFF); idle(2);
    chk_stat("R8 pre", 16'h0000);
    @(negedge clk); pin_in = 16'h0008;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_ACK; bus_wdata = 16'h0008;
    @(negedge clk);
    bus_wr = 1'b0;
    idle(2);
    chk_stat("R8 collision", 16'h0008);
    wr(A_ACK, 16'h0008); idle(2);
    chk_stat("R8 later ack", 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule